// File: doc/BRIEF.md
# SIMT Execution Mask Sequencer

This block holds the 64-lane active-lane mask of a wavefront processor and applies the scalar mask operations with which divergent control flow is compiled: entering and flipping a two-way branch, rejoining after it, accumulating loop-exit lanes, closing a loop, and retiring lanes by kill. A small file of 64-bit saved-mask registers holds lanes set aside by one command for use by a later one. The block does not keep a push/pop stack. Every command is an exact save-and-modify bitwise operation on the mask and on the registers it names.

A command is accepted on a valid/ready handshake and takes effect at that clock edge. In the cycle after acceptance the block presents a response strobe, the updated mask, an idle flag that is high when no lane remains active, and a branch-taken flag. The branch-taken flag is used by the closing command of a loop and by the skip-if-idle command. The sequencer that issues the commands owns the branching decisions. This block only reports the conditions that the sequencer branches on.

Top module: `lane_mask_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the mask is all ones, every saved-mask register is zero and `rsp_valid` is low. `cmd_ready` is low during reset and goes high in the cycle after reset is released.
- R2: A command is accepted only at an edge where `cmd_valid` and `cmd_ready` are both high. Its results appear on `rsp_mask`, `rsp_idle` and `rsp_taken` in the next cycle, together with a one-cycle `rsp_valid`. A cycle with no acceptance leaves the mask and the saved registers unchanged.
- R3: Opcode 0 (if): the new mask is the old mask AND `cmd_cond`, and register `cmd_dst` receives the old mask AND NOT `cmd_cond`, which are the lanes that failed the condition.
- R4: Opcode 1 (else): register `cmd_dst` receives the old mask, and the new mask is register `cmd_src` AND NOT the old mask. `cmd_dst` may equal `cmd_src`. The result is the same whether `cmd_exec_mod` is high or low.
- R5: Opcode 2 (rejoin): the new mask is the old mask OR register `cmd_src`.
- R6: Opcode 3 writes mask OR reg[`cmd_src`] into reg[`cmd_dst`]. Opcode 4 writes `cmd_cond` OR reg[`cmd_src`]. Opcode 5 writes reg[`cmd_imm`[2:0]] OR reg[`cmd_src`]. None of the three changes the mask.
- R7: Opcode 6 (loop close): the new mask is the old mask AND NOT register `cmd_src`, and `rsp_taken` is high exactly when that new mask is nonzero.
- R8: Opcode 7 (immediate kill): when `cmd_imm` bit 31 is set the mask becomes zero. Otherwise the mask is unchanged.
- R9: Opcode 8 (lane kill): every lane whose `cmd_cond` bit is set is cleared from the mask, and the other lanes keep their state.
- R10: Opcode 9 (skip if idle): the mask is unchanged, and `rsp_taken` is high exactly when the mask is all zeros.
- R11: After every accepted command, `rsp_idle` is high exactly when the new mask is zero. Opcodes 0 to 5, 7 and 8 drive `rsp_taken` low. Opcodes 10 to 15 change nothing and drive `rsp_taken` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 4 | Command code |
| cmd_dst | input | 3 | Saved-register index written |
| cmd_src | input | 3 | Saved-register index read |
| cmd_cond | input | 64 | Per-lane condition or kill mask |
| cmd_imm | input | 32 | Immediate; bit 31 is the kill sign, bits 2:0 the second read index |
| cmd_exec_mod | input | 1 | Mask was modified before an else command |
| rsp_valid | output | 1 | Result of an accepted command is shown |
| rsp_mask | output | 64 | Current active-lane mask |
| rsp_idle | output | 1 | No lane active |
| rsp_taken | output | 1 | Branch condition of the last command |

## Verification
The assertions take the command fields to be stable and defined in every cycle where `cmd_valid` is high. They compare each result only with the inputs captured at the accepting edge. The stimulus changes inputs only on the falling edge and holds them through the next rising edge. It keeps the saved-register indices and the else-break immediate index within the eight registers. The stimulus also drives the undefined opcodes on purpose, so that the requirement that those opcodes have no effect is exercised.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;

    typedef enum logic [3:0] {
        OP_IF      = 4'd0,
        OP_ELSE    = 4'd1,
        OP_REJOIN  = 4'd2,
        OP_BRK     = 4'd3,
        OP_IFBRK   = 4'd4,
        OP_ELSEBRK = 4'd5,
        OP_LOOP    = 4'd6,
        OP_KILLI   = 4'd7,
        OP_KILLV   = 4'd8,
        OP_SKIPZ   = 4'd9
    } lm_op_e;

endpackage

// File: rtl/lane_mask_file.sv
module lane_mask_file #(
    parameter int LANES = 64,
    parameter int NREGS = 8,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDXW-1:0]  waddr,
    input  logic [LANES-1:0] wdata,
    input  logic [IDXW-1:0]  raddr_a,
    input  logic [IDXW-1:0]  raddr_b,
    output logic [LANES-1:0] rdata_a,
    output logic [LANES-1:0] rdata_b
);

    logic [LANES-1:0] regs_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [LANES-1:0] reg_d;

        always_comb begin
            reg_d = regs_q[g];
            if (we && (waddr == IDXW'(g))) begin
                reg_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= reg_d;
            end
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/lane_mask_alu.sv
module lane_mask_alu
    import lane_mask_pkg::*;
#(
    parameter int LANES = 64
) (
    input  lm_op_e           op,
    input  logic [LANES-1:0] mask,
    input  logic [LANES-1:0] cond,
    input  logic             kill_sign,
    input  logic             exec_mod,
    input  logic [LANES-1:0] src_val,
    input  logic [LANES-1:0] aux_val,
    output logic [LANES-1:0] mask_nxt,
    output logic             wr_en,
    output logic [LANES-1:0] wr_val,
    output logic             taken
);

    logic [LANES-1:0] narrowed;
    logic [LANES-1:0] widened;
    logic [LANES-1:0] kept;

    always_comb begin
        mask_nxt = mask;
        wr_en    = 1'b0;
        wr_val   = '0;
        taken    = 1'b0;
        narrowed = mask & cond;
        widened  = mask | src_val;
        kept     = mask;
        case (op)
            OP_IF: begin
                mask_nxt = narrowed;
                wr_en    = 1'b1;
                wr_val   = narrowed ^ mask;
            end
            OP_ELSE: begin
                if (exec_mod) begin
                    kept = widened & mask;
                end
                mask_nxt = widened ^ kept;
                wr_en    = 1'b1;
                wr_val   = kept;
            end
            OP_REJOIN: begin
                mask_nxt = widened;
            end
            OP_BRK: begin
                wr_en  = 1'b1;
                wr_val = widened;
            end
            OP_IFBRK: begin
                wr_en  = 1'b1;
                wr_val = cond | src_val;
            end
            OP_ELSEBRK: begin
                wr_en  = 1'b1;
                wr_val = aux_val | src_val;
            end
            OP_LOOP: begin
                mask_nxt = mask & ~src_val;
                taken    = |(mask & ~src_val);
            end
            OP_KILLI: begin
                if (kill_sign) begin
                    mask_nxt = '0;
                end
            end
            OP_KILLV: begin
                mask_nxt = mask & ~cond;
            end
            OP_SKIPZ: begin
                taken = ~|mask;
            end
            default: begin
                mask_nxt = mask;
            end
        endcase
    end

endmodule

// File: rtl/lane_mask_seq.sv
module lane_mask_seq
    import lane_mask_pkg::*;
#(
    parameter int LANES = 64,
    parameter int NREGS = 8,
    parameter int IMMW  = 32,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [3:0]       cmd_op,
    input  logic [IDXW-1:0]  cmd_dst,
    input  logic [IDXW-1:0]  cmd_src,
    input  logic [LANES-1:0] cmd_cond,
    input  logic [IMMW-1:0]  cmd_imm,
    input  logic             cmd_exec_mod,
    output logic             rsp_valid,
    output logic [LANES-1:0] rsp_mask,
    output logic             rsp_idle,
    output logic             rsp_taken
);

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic             taken;
        logic             idle;
        logic             vld;
        logic             rdy;
    } seq_state_t;

    seq_state_t st_d;
    seq_state_t st_q;

    logic             accept;
    logic [LANES-1:0] src_val;
    logic [LANES-1:0] aux_val;
    logic [LANES-1:0] alu_mask;
    logic             alu_wr;
    logic [LANES-1:0] alu_wval;
    logic             alu_taken;
    logic             unused_imm_bits;

    assign accept          = cmd_valid && st_q.rdy;
    assign unused_imm_bits = ^cmd_imm[IMMW-2:IDXW];

    lane_mask_file #(
        .LANES (LANES),
        .NREGS (NREGS)
    ) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (accept && alu_wr),
        .waddr   (cmd_dst),
        .wdata   (alu_wval),
        .raddr_a (cmd_src),
        .raddr_b (cmd_imm[IDXW-1:0]),
        .rdata_a (src_val),
        .rdata_b (aux_val)
    );

    lane_mask_alu #(
        .LANES (LANES)
    ) u_alu (
        .op        (lm_op_e'(cmd_op)),
        .mask      (st_q.mask),
        .cond      (cmd_cond),
        .kill_sign (cmd_imm[IMMW-1]),
        .exec_mod  (cmd_exec_mod),
        .src_val   (src_val),
        .aux_val   (aux_val),
        .mask_nxt  (alu_mask),
        .wr_en     (alu_wr),
        .wr_val    (alu_wval),
        .taken     (alu_taken)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b1;
        st_d.vld = accept;
        if (accept) begin
            st_d.mask  = alu_mask;
            st_d.taken = alu_taken;
            st_d.idle  = ~|alu_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask  <= '1;
            st_q.taken <= 1'b0;
            st_q.idle  <= 1'b0;
            st_q.vld   <= 1'b0;
            st_q.rdy   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready = st_q.rdy;
    assign rsp_valid = st_q.vld;
    assign rsp_mask  = st_q.mask;
    assign rsp_idle  = st_q.idle;
    assign rsp_taken = st_q.taken;

endmodule

// File: rtl/lane_mask_seq_chk.sv
module lane_mask_seq_chk
    import lane_mask_pkg::*;
#(
    parameter int LANES = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [3:0]       cmd_op,
    input logic [LANES-1:0] cmd_cond,
    input logic             rsp_valid,
    input logic [LANES-1:0] rsp_mask,
    input logic             rsp_idle,
    input logic             rsp_taken
);

    logic acc;
    assign acc = cmd_valid && cmd_ready;

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc)) else $error("rsp_valid without accept"); // R2

    AST_HOLD_WHEN_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(rsp_mask)) else $error("mask moved without a command"); // R2

    AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_idle == (rsp_mask == '0))) else $error("idle flag mismatch"); // R11

    AST_IF_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == OP_IF) |=> ((rsp_mask & ~$past(cmd_cond)) == '0)) else $error("if kept a failing lane"); // R3

    AST_LOOP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == OP_LOOP) |=> (rsp_taken == (rsp_mask != '0))) else $error("loop taken mismatch"); // R7

    AST_KILLV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == OP_KILLV) |=> ((rsp_mask & $past(cmd_cond)) == '0)) else $error("killed lane still active"); // R9

    AST_SKIP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == OP_SKIPZ) |=> (rsp_taken == (rsp_mask == '0))) else $error("skip flag mismatch"); // R10

endmodule

bind lane_mask_seq lane_mask_seq_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_cond  (cmd_cond),
    .rsp_valid (rsp_valid),
    .rsp_mask  (rsp_mask),
    .rsp_idle  (rsp_idle),
    .rsp_taken (rsp_taken)
);

// File: tb/sim_lane_mask_seq.sv
module sim_lane_mask_seq;
    import lane_mask_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 22;

    typedef struct packed {
        logic [3:0]  op;
        logic [2:0]  dst;
        logic [2:0]  src;
        logic [63:0] cond;
        logic [31:0] imm;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'd0, 3'd1, 3'd0, 64'h0000_0000_FFFF_FFFF, 32'h0},
        '{4'd1, 3'd2, 3'd1, 64'h0, 32'h0},
        '{4'd2, 3'd0, 3'd2, 64'h0, 32'h0},
        '{4'd0, 3'd3, 3'd0, 64'hAAAA_AAAA_AAAA_AAAA, 32'h0},
        '{4'd0, 3'd4, 3'd0, 64'hFF00_FF00_FF00_FF00, 32'h0},
        '{4'd2, 3'd0, 3'd4, 64'h0, 32'h0},
        '{4'd2, 3'd0, 3'd3, 64'h0, 32'h0},
        '{4'd6, 3'd0, 3'd0, 64'h0, 32'h0},
        '{4'd3, 3'd5, 3'd0, 64'h0, 32'h0},
        '{4'd4, 3'd6, 3'd0, 64'h0000_0000_0000_000F, 32'h0},
        '{4'd5, 3'd7, 3'd6, 64'h0, 32'h3},
        '{4'd6, 3'd0, 3'd7, 64'h0, 32'h0},
        '{4'd6, 3'd0, 3'd6, 64'h0, 32'h0},
        '{4'd6, 3'd0, 3'd5, 64'h0, 32'h0},
        '{4'd9, 3'd0, 3'd0, 64'h0, 32'h0},
        '{4'd2, 3'd0, 3'd5, 64'h0, 32'h0},
        '{4'd7, 3'd0, 3'd0, 64'h0, 32'h7FFF_FFFF},
        '{4'd8, 3'd0, 3'd0, 64'hFFFF_0000_0000_0000, 32'h0},
        '{4'd9, 3'd0, 3'd0, 64'h0, 32'h0},
        '{4'd7, 3'd0, 3'd0, 64'h0, 32'h8000_0000},
        '{4'd2, 3'd0, 3'd1, 64'h0, 32'h0},
        '{4'd15, 3'd1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cmd_op = 4'd15;
    logic [2:0]  cmd_dst = '0;
    logic [2:0]  cmd_src = '0;
    logic [63:0] cmd_cond = '0;
    logic [31:0] cmd_imm = '0;
    logic        cmd_exec_mod = 1'b0;
    logic        rsp_valid;
    logic [63:0] rsp_mask;
    logic        rsp_idle;
    logic        rsp_taken;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_mask;
    logic [63:0] m_reg [8];
    logic        m_taken;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_mask_seq u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_op       (cmd_op),
        .cmd_dst      (cmd_dst),
        .cmd_src      (cmd_src),
        .cmd_cond     (cmd_cond),
        .cmd_imm      (cmd_imm),
        .cmd_exec_mod (cmd_exec_mod),
        .rsp_valid    (rsp_valid),
        .rsp_mask     (rsp_mask),
        .rsp_idle     (rsp_idle),
        .rsp_taken    (rsp_taken)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3, 4'd4, 4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            4'd9: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_mask  = '1;
        m_taken = 1'b0;
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
    endtask

    task automatic model_apply(input vec_t v);
        logic [63:0] s;
        s = m_reg[v.src];
        m_taken = 1'b0;
        case (v.op)
            4'd0: begin m_reg[v.dst] = m_mask & ~v.cond; m_mask = m_mask & v.cond; end
            4'd1: begin m_reg[v.dst] = m_mask; m_mask = s & ~m_mask; end
            4'd2: m_mask = m_mask | s;
            4'd3: m_reg[v.dst] = m_mask | s;
            4'd4: m_reg[v.dst] = v.cond | s;
            4'd5: m_reg[v.dst] = m_reg[v.imm[2:0]] | s;
            4'd6: begin m_mask = m_mask & ~s; m_taken = (m_mask != 0); end
            4'd7: if (v.imm[31]) m_mask = '0;
            4'd8: m_mask = m_mask & ~v.cond;
            4'd9: m_taken = (m_mask == 0);
            default: ;
        endcase
    endtask

    // called at a falling edge; returns at the next falling edge with results shown
    task automatic issue(input vec_t v, input logic mod);
        cmd_op = v.op; cmd_dst = v.dst; cmd_src = v.src;
        cmd_cond = v.cond; cmd_imm = v.imm; cmd_exec_mod = mod;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        model_apply(v);
        chk(req_of(v.op), "mask", rsp_mask, m_mask);
        chk(req_of(v.op), "taken", {63'd0, rsp_taken}, {63'd0, m_taken});
        chk("R11", "idle", {63'd0, rsp_idle}, {63'd0, m_mask == 0});
        chk("R2", "rsp_valid", {63'd0, rsp_valid}, 64'd1);
    endtask

    task automatic read_reg(input logic [2:0] r, input string req);
        issue('{4'd7, 3'd0, 3'd0, 64'h0, 32'h8000_0000}, 1'b0);
        issue('{4'd2, 3'd0, r, 64'h0, 32'h0}, 1'b0);
        chk(req, "saved readback", rsp_mask, m_reg[r]);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1", "mask in reset", rsp_mask, '1);
        chk("R1", "valid in reset", {63'd0, rsp_valid}, 64'd0);
        chk("R1", "ready in reset", {63'd0, cmd_ready}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", {63'd0, cmd_ready}, 64'd1);
        chk("R1", "mask after reset", rsp_mask, '1);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i], 1'b0);
        end

        // R2: command held without valid has no effect
        issue('{4'd2, 3'd0, 3'd5, 64'h0, 32'h0}, 1'b0);
        cmd_op = 4'd7; cmd_imm = 32'h8000_0000; cmd_valid = 1'b0;
        @(negedge clk);
        chk("R2", "mask without valid", rsp_mask, m_mask);
        chk("R2", "rsp_valid without valid", {63'd0, rsp_valid}, 64'd0);

        // R4: else with the modified flag, then src equal to dst
        issue('{4'd0, 3'd1, 3'd0, 64'h0F0F_0000_1234_5678, 32'h0}, 1'b0);
        issue('{4'd1, 3'd2, 3'd1, 64'h0, 32'h0}, 1'b1);
        read_reg(3'd2, "R4");
        issue('{4'd2, 3'd0, 3'd5, 64'h0, 32'h0}, 1'b0);
        issue('{4'd0, 3'd4, 3'd0, 64'hFFFF_FFFF_0000_0001, 32'h0}, 1'b0);
        issue('{4'd1, 3'd4, 3'd4, 64'h0, 32'h0}, 1'b1);
        read_reg(3'd4, "R4");

        // R1: reset mid-run restores mask and clears the saved registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk("R1", "mask after second reset", rsp_mask, '1);
        @(negedge clk);
        read_reg(3'd5, "R1");
        read_reg(3'd7, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule